// File: doc/BRIEF.md
# CAN Fault-Confinement State Tracker

This block watches a CAN controller's error reporting and turns it into a fault-confinement state and a stream of short events. When the host logic has freshly read the error-flag byte, the warning bit of the status byte and the two error counters, it pulses `sample_stb`. On that edge the block decides which confinement state applies. If the state differs from the one it holds, it raises a one-cycle event. The event says whether the transmit side, the receive side or both are blamed for the change, depending on which counter is larger.

On the same strobe, a pending bus-error interrupt with error reporting enabled makes the block reduce the five protocol-error flags to a single cause code. If the block enters bus-off while automatic recovery is off, it raises a sleep request and freezes. Only a restart pulse leaves that condition.

Top module: `cest_tracker`

## Requirements
- R1: After reset `fc_state` is active (0), `sleep_req` is 0, and `evt_valid` and `cause_valid` are both 0.
- R2: `fc_state` is encoded as active=0, warning=1, passive=2, bus-off=3. On an accepted strobe the new state is chosen by priority. It is bus-off if `err_flags[7]` is set. Otherwise it is passive if `err_flags[6]` or `err_flags[5]` is set. Otherwise it is warning if `status_warn` is set. Otherwise it is active.
- R3: `evt_valid` is high for exactly the cycle after an accepted strobe whose decided state differs from the state held before. It is low after any other strobe and after a restart.
- R4: During an event, `evt_tx_side` is 1 exactly when `tec >= rec` and `evt_rx_side` is 1 exactly when `tec <= rec`, using the sampled counters. Both are 0 outside events.
- R5: Every accepted strobe loads `snap_tec` and `snap_rec` with the sampled `tec` and `rec`. They are held otherwise, so an event or cause pulse always shows the counters taken with it.
- R6: `cause_valid` pulses for one cycle after an accepted strobe only if `bus_err_irq`, `berr_report_en` and at least one of `err_flags[4:0]` are all set. No cause is reported on a strobe that halts the block. `cause_code` is 0 whenever `cause_valid` is low.
- R7: Cause codes follow a fixed priority over the protocol flags. Bit error (`err_flags[4]`) gives 1, form (`[3]`) gives 2, stuff (`[0]`) gives 3, CRC (`[2]`) gives 4 and ACK (`[1]`) gives 5.
- R8: A strobe that moves the state into bus-off while `auto_restart_en` is 0 sets `sleep_req`. From then on, strobes change nothing: no state change, no event and no cause.
- R9: A `restart` pulse returns `fc_state` to active, clears `sleep_req` and produces no event. It takes precedence over a strobe in the same cycle.
- R10: While `sample_stb` is low, changes on the flag, counter and interrupt inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | Inputs below are fresh; evaluate on this edge |
| err_flags | input | 8 | Controller error-flag byte |
| status_warn | input | 1 | Warning bit of the status byte |
| tec | input | CNT_W | Transmit error counter |
| rec | input | CNT_W | Receive error counter |
| bus_err_irq | input | 1 | Bus-error interrupt pending |
| berr_report_en | input | 1 | Protocol cause reporting enabled |
| auto_restart_en | input | 1 | Automatic bus-off recovery enabled |
| restart | input | 1 | Return to active and release a halt |
| fc_state | output | 2 | Current confinement state |
| sleep_req | output | 1 | Halted in bus-off; controller should sleep |
| evt_valid | output | 1 | One-cycle state-change event |
| evt_tx_side | output | 1 | Transmit side reports the change |
| evt_rx_side | output | 1 | Receive side reports the change |
| cause_valid | output | 1 | One-cycle protocol cause event |
| cause_code | output | 3 | Protocol cause code |
| snap_tec | output | CNT_W | TEC captured at the last accepted strobe |
| snap_rec | output | CNT_W | REC captured at the last accepted strobe |

## Verification
A wrong held state shows up at the ports on the next strobe. An event then fires when none is due or is missing when one is, and the step after that shows a wrong `fc_state` directly. A halt flag stuck high or low shows up at once as a wrong `sleep_req`, and on the next strobe as accepted or ignored updates. Because every output is registered one edge after its strobe, each fault is visible in the cycle after the vector that exposes it. The sweep covers every flag byte with the warning bit, interrupt and enable combinations.

// File: rtl/cest_pkg.sv
// Shared types for the CAN fault-confinement tracker.
// Assumes an 8-bit error-flag byte whose top three bits report confinement
// and whose low five bits report protocol errors.
package cest_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_WARNING = 2'd1,
        FC_PASSIVE = 2'd2,
        FC_BUSOFF  = 2'd3
    } fc_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_BIT   = 3'd1,
        CAUSE_FORM  = 3'd2,
        CAUSE_STUFF = 3'd3,
        CAUSE_CRC   = 3'd4,
        CAUSE_ACK   = 3'd5
    } cause_e;

    localparam int FLAG_W      = 8;
    localparam int PROTO_W     = 5;
    localparam int BIT_BUSOFF  = 7;
    localparam int BIT_TXPASS  = 6;
    localparam int BIT_RXPASS  = 5;

endpackage

// File: rtl/cest_state_decode.sv
// Decides the confinement state from one flag sample.
// Purely combinational; priority: bus-off, passive, warning, active.
module cest_state_decode
    import cest_pkg::*;
(
    input  logic [FLAG_W-1:0] err_flags,
    input  logic              status_warn,
    output fc_state_e         next_state
);

    // Priority selection of the confinement state
    always_comb begin
        if (err_flags[BIT_BUSOFF])
            next_state = FC_BUSOFF;
        else if (err_flags[BIT_TXPASS] || err_flags[BIT_RXPASS])
            next_state = FC_PASSIVE;
        else if (status_warn)
            next_state = FC_WARNING;
        else
            next_state = FC_ACTIVE;
    end

endmodule

// File: rtl/cest_cause_encode.sv
// Reduces the protocol-error flags to one cause code.
// Assumes flag positions: stuff=0, ack=1, crc=2, form=3, bit=4.
// The rank table lists flag positions from highest to lowest priority;
// the code of rank k is k+1.
module cest_cause_encode
    import cest_pkg::*;
(
    input  logic [PROTO_W-1:0] proto_flags,
    output logic               any_err,
    output logic [2:0]         code
);

    localparam int RANK [PROTO_W] = '{4, 3, 0, 2, 1};

    // Scan from lowest to highest priority so the highest set flag wins
    always_comb begin
        code = CAUSE_NONE;
        for (int k = PROTO_W - 1; k >= 0; k--) begin
            if (proto_flags[RANK[k]])
                code = 3'(k + 1);
        end
    end

    // Any protocol flag present
    assign any_err = |proto_flags;

endmodule

// File: rtl/cest_attrib.sv
// Attributes a state change to the transmit and/or receive side by
// comparing the error counters; equal counters blame both sides.
module cest_attrib #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    output logic             tx_side,
    output logic             rx_side
);

    // Counter comparison for side attribution
    always_comb begin
        tx_side = (tec >= rec);
        rx_side = (tec <= rec);
    end

endmodule

// File: rtl/cest_tracker.sv
// Fault-confinement tracker top. On each strobe it registers the decided
// state, a one-cycle change event with side attribution, an optional
// protocol cause and a snapshot of the counters. Entering bus-off without
// auto-restart halts updates and requests sleep until restart.
// Assumes the caller strobes only when all sampled inputs are coherent.
module cest_tracker
    import cest_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [7:0]        err_flags,
    input  logic              status_warn,
    input  logic [CNT_W-1:0]  tec,
    input  logic [CNT_W-1:0]  rec,
    input  logic              bus_err_irq,
    input  logic              berr_report_en,
    input  logic              auto_restart_en,
    input  logic              restart,
    output logic [1:0]        fc_state,
    output logic              sleep_req,
    output logic              evt_valid,
    output logic              evt_tx_side,
    output logic              evt_rx_side,
    output logic              cause_valid,
    output logic [2:0]        cause_code,
    output logic [CNT_W-1:0]  snap_tec,
    output logic [CNT_W-1:0]  snap_rec
);

    fc_state_e          state_q;
    fc_state_e          next_state;
    logic               halted_q;
    logic               tx_side, rx_side;
    logic               proto_any;
    logic [2:0]         proto_code;
    logic               accept;
    logic               changed;
    logic               halt_now;
    logic               report_now;

    cest_state_decode u_decode (
        .err_flags   (err_flags),
        .status_warn (status_warn),
        .next_state  (next_state)
    );

    cest_cause_encode u_cause (
        .proto_flags (err_flags[PROTO_W-1:0]),
        .any_err     (proto_any),
        .code        (proto_code)
    );

    cest_attrib #(.CNT_W(CNT_W)) u_attrib (
        .tec     (tec),
        .rec     (rec),
        .tx_side (tx_side),
        .rx_side (rx_side)
    );

    // Qualify the strobe and classify its consequences
    always_comb begin
        accept     = sample_stb && !halted_q && !restart;
        changed    = accept && (next_state != state_q);
        halt_now   = changed && (next_state == FC_BUSOFF) && !auto_restart_en;
        report_now = accept && !halt_now && bus_err_irq && berr_report_en && proto_any;
    end

    // State, halt and event registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FC_ACTIVE;
            halted_q    <= 1'b0;
            evt_valid   <= 1'b0;
            evt_tx_side <= 1'b0;
            evt_rx_side <= 1'b0;
            cause_valid <= 1'b0;
            cause_code  <= CAUSE_NONE;
            snap_tec    <= '0;
            snap_rec    <= '0;
        end else begin
            evt_valid   <= changed;
            evt_tx_side <= changed && tx_side;
            evt_rx_side <= changed && rx_side;
            cause_valid <= report_now;
            cause_code  <= report_now ? proto_code : CAUSE_NONE;
            if (restart) begin
                state_q  <= FC_ACTIVE;
                halted_q <= 1'b0;
            end else if (accept) begin
                state_q  <= next_state;
                snap_tec <= tec;
                snap_rec <= rec;
                if (halt_now)
                    halted_q <= 1'b1;
            end
        end
    end

    // Port views of internal state
    assign fc_state  = state_q;
    assign sleep_req = halted_q;

endmodule

// File: rtl/cest_tracker_chk.sv
// Assertion checker for cest_tracker, attached by bind below.
module cest_tracker_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_stb,
    input logic             restart,
    input logic             bus_err_irq,
    input logic             berr_report_en,
    input logic [1:0]       fc_state,
    input logic             sleep_req,
    input logic             evt_valid,
    input logic             evt_tx_side,
    input logic             evt_rx_side,
    input logic             cause_valid,
    input logic [2:0]       cause_code,
    input logic [CNT_W-1:0] snap_tec,
    input logic [CNT_W-1:0] snap_rec
);

    // R3
    state_moves_with_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(restart) && fc_state != $past(fc_state)) |-> evt_valid);

    // R3
    event_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(sample_stb));

    // R4
    side_attrib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_tx_side == (snap_tec >= snap_rec)) && (evt_rx_side == (snap_tec <= snap_rec)));

    // R6
    cause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_valid |-> (cause_code != 3'd0) && $past(bus_err_irq && berr_report_en && sample_stb));

    // R8
    sleep_in_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req) |-> (fc_state == 2'd3) && evt_valid);

    // R8
    halt_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !restart) |=> $stable(fc_state) && !evt_valid && !cause_valid);

    // R9
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (fc_state == 2'd0) && !sleep_req && !evt_valid);

endmodule

bind cest_tracker cest_tracker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_stb     (sample_stb),
    .restart        (restart),
    .bus_err_irq    (bus_err_irq),
    .berr_report_en (berr_report_en),
    .fc_state       (fc_state),
    .sleep_req      (sleep_req),
    .evt_valid      (evt_valid),
    .evt_tx_side    (evt_tx_side),
    .evt_rx_side    (evt_rx_side),
    .cause_valid    (cause_valid),
    .cause_code     (cause_code),
    .snap_tec       (snap_tec),
    .snap_rec       (snap_rec)
);

// File: tb/tb_cest_tracker.sv
// Self-checking bench: full sweep of flag bytes with warning, interrupt and
// enable combinations, then directed halt and restart sequences.
module tb_cest_tracker;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sample_stb = 1'b0;
    logic [7:0]       err_flags = '0;
    logic             status_warn = 1'b0;
    logic [CNT_W-1:0] tec = '0;
    logic [CNT_W-1:0] rec = '0;
    logic             bus_err_irq = 1'b0;
    logic             berr_report_en = 1'b0;
    logic             auto_restart_en = 1'b1;
    logic             restart = 1'b0;
    logic [1:0]       fc_state;
    logic             sleep_req;
    logic             evt_valid, evt_tx_side, evt_rx_side;
    logic             cause_valid;
    logic [2:0]       cause_code;
    logic [CNT_W-1:0] snap_tec, snap_rec;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5ns clk = ~clk;

    cest_tracker #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .err_flags(err_flags), .status_warn(status_warn), .tec(tec), .rec(rec),
        .bus_err_irq(bus_err_irq), .berr_report_en(berr_report_en),
        .auto_restart_en(auto_restart_en), .restart(restart),
        .fc_state(fc_state), .sleep_req(sleep_req), .evt_valid(evt_valid),
        .evt_tx_side(evt_tx_side), .evt_rx_side(evt_rx_side),
        .cause_valid(cause_valid), .cause_code(cause_code),
        .snap_tec(snap_tec), .snap_rec(snap_rec)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_state(input logic [7:0] f, input logic w);
        if (f[7]) return 3;
        if (f[6] | f[5]) return 2;
        if (w) return 1;
        return 0;
    endfunction

    function automatic int model_cause(input logic [7:0] f);
        if (f[4]) return 1;
        if (f[3]) return 2;
        if (f[0]) return 3;
        if (f[2]) return 4;
        if (f[1]) return 5;
        return 0;
    endfunction

    // Drive one strobed sample, then settle to the next falling edge
    task automatic strobe(input logic [7:0] f, input logic w, input int t, input int r,
                          input logic irq, input logic en);
        err_flags = f; status_warn = w; tec = CNT_W'(t); rec = CNT_W'(r);
        bus_err_irq = irq; berr_report_en = en; sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    initial begin
        #2_000_000ns;
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int exp_state;
        int snap_t;
        int snap_r;
        exp_state = 0;
        snap_t = 0;
        snap_r = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 state", fc_state, 0);
        check("R1 sleep", sleep_req, 0);
        check("R1 evt", evt_valid, 0);
        check("R1 cause", cause_valid, 0);

        // Sweep with auto-restart enabled so bus-off never halts
        auto_restart_en = 1'b1;
        for (int i = 0; i < 2048; i++) begin
            logic [7:0] f;
            logic w, irq, en;
            int t, r, ns, ec, ev;
            f = i[7:0]; w = i[8]; irq = i[9]; en = i[10];
            t = (i * 37) % 256;
            r = (i % 7 == 0) ? t : (i * 11 + 3) % 256;
            ns = model_state(f, w);
            ev = (ns != exp_state) ? 1 : 0;
            ec = (irq && en && (f[4:0] != 0)) ? model_cause(f) : 0;
            strobe(f, w, t, r, irq, en);
            check("R2 state", fc_state, ns);
            check("R3 event", evt_valid, ev);
            check("R4 tx side", evt_tx_side, ev ? int'(t >= r) : 0);
            check("R4 rx side", evt_rx_side, ev ? int'(t <= r) : 0);
            check("R5 tec", snap_tec, t);
            check("R5 rec", snap_rec, r);
            check("R6 cause valid", cause_valid, ec != 0);
            check("R7 cause code", cause_code, ec);
            check("R8 no halt", sleep_req, 0);
            exp_state = ns;
            snap_t = t;
            snap_r = r;
        end

        // R10: input changes without strobe have no effect
        err_flags = 8'h9F; status_warn = 1'b1; tec = 8'd77; rec = 8'd66;
        bus_err_irq = 1'b1; berr_report_en = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R10 state", fc_state, exp_state);
        check("R10 evt", evt_valid, 0);
        check("R10 cause", cause_valid, 0);
        check("R10 tec", snap_tec, snap_t);
        check("R10 rec", snap_rec, snap_r);

        // R9: restart returns to active without an event
        pulse_restart();
        check("R9 state", fc_state, 0);
        check("R9 evt", evt_valid, 0);

        // R8: bus-off entry without auto-restart halts, no cause
        auto_restart_en = 1'b0;
        strobe(8'h90, 1'b0, 5, 200, 1'b1, 1'b1);
        check("R8 state", fc_state, 3);
        check("R8 evt", evt_valid, 1);
        check("R4 rx only", evt_rx_side, 1);
        check("R4 tx off", evt_tx_side, 0);
        check("R8 sleep", sleep_req, 1);
        check("R6 suppressed at halt", cause_valid, 0);
        for (int k = 0; k < 4; k++) begin
            strobe(8'h08 << (k % 2), logic'(k[0]), 10 + k, 20, 1'b1, 1'b1);
            check("R8 frozen state", fc_state, 3);
            check("R8 frozen evt", evt_valid, 0);
            check("R8 frozen cause", cause_valid, 0);
            check("R8 frozen tec", snap_tec, 5);
            check("R8 sleep held", sleep_req, 1);
        end

        // R9: restart has precedence over a same-cycle strobe
        err_flags = 8'h20; sample_stb = 1'b1; restart = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0; restart = 1'b0;
        check("R9 state after restart", fc_state, 0);
        check("R9 sleep cleared", sleep_req, 0);
        check("R9 no event", evt_valid, 0);

        // Updates resume after restart
        strobe(8'h20, 1'b0, 40, 40, 1'b0, 1'b1);
        check("R2 passive resumed", fc_state, 2);
        check("R3 event resumed", evt_valid, 1);
        check("R4 equal both tx", evt_tx_side, 1);
        check("R4 equal both rx", evt_rx_side, 1);
        @(negedge clk);
        check("R3 one cycle", evt_valid, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule